// File: doc/BRIEF.md
# Post-Decode Incrementing Row Select Bank

This block is a small register-file-style memory bank. Its row selection does not add one to the binary row address. The address is first decoded into a one-hot set of word lines. When the increment flag is raised, each word line takes the decoded line of the row beneath it instead of its own. The selected row therefore moves up by one, and no carry chain lies on the address path. The top row's decoded line feeds row 0, so an incremented access at the top address lands on row 0.

The selected row drives a storage array of `WIDTH`-bit words. A write stores data into that row at the clock edge. A read captures the row's word into an output register, so the data appears one cycle after the request. The one-hot enable vector is also brought out, so a neighbouring bank can share the same selection.

Top module: `postinc_row_bank`

## Requirements
- R1: After reset, `rdData` is zero and every row holds zero.
- R2: For every combination of `rowAddr` and `incr`, exactly one bit of `rowEnable` is set.
- R3: With `incr` low, the set bit of `rowEnable` is bit `rowAddr`, in the same cycle as the inputs.
- R4: With `incr` high and `rowAddr` below the top row, the set bit is bit `rowAddr + 1`.
- R5: With `incr` high and `rowAddr` at the top row (`ROWS-1`), the set bit is bit 0.
- R6: A clock edge with `wrEn` high stores `wrData` into the enabled row and leaves every other row unchanged.
- R7: A clock edge with `rdEn` high loads `rdData` with the enabled row's word as it stood before that edge. A write in the same cycle is not seen until a later read.
- R8: While `rdEn` is low, `rdData` keeps its value, whatever happens to the address and to writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rowAddr | input | ROW_BITS | Binary row address |
| incr | input | 1 | Select the row one above `rowAddr` |
| wrEn | input | 1 | Write request for the enabled row |
| wrData | input | WIDTH | Word to write |
| rdEn | input | 1 | Read request for the enabled row |
| rdData | output | WIDTH | Registered read word |
| rowEnable | output | ROWS | One-hot word-line enables |

## Verification
A wrong neighbour connection in the selector shows up at once on `rowEnable`, in the same cycle as the address. An exhaustive sweep of address and flag catches it directly. The same fault also sends a write to the wrong row. That second effect only becomes visible when that row is read back, which takes one cycle for the read to register, so the bench reads back every row after writing through the incremented path. A read register that fails to hold, or that captures after the write, shows on `rdData` at the first edge where the ordering matters.

// File: rtl/rowbank_pkg.sv
package rowbank_pkg;
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } bankStrobe_t;
endpackage

// File: rtl/rowbank_select.sv
module rowbank_select
  import rowbank_pkg::*;
#(
  parameter int ROW_BITS = 4,
  localparam int ROWS = 1 << ROW_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ROW_BITS-1:0] rowAddr,
  input  logic                incr,
  input  logic                wrEn,
  input  logic                rdEn,
  output logic [ROWS-1:0]     rowEn,
  output bankStrobe_t         strb
);
  localparam logic [ROW_BITS-1:0] ONE_ROW = 1;
  localparam logic [ROW_BITS-1:0] TOP_ROW = ROW_BITS'(ROWS - 1);

  logic [ROWS-1:0] decLine;

  // full binary-to-one-hot decode, one line per row
  for (genvar i = 0; i < ROWS; i++) begin : g_dec
    assign decLine[i] = (rowAddr == ROW_BITS'(i));
  end

  // per-row 2:1 neighbour mux; row 0 borrows the top row's line
  for (genvar i = 0; i < ROWS; i++) begin : g_mux
    localparam int BELOW = (i == 0) ? ROWS - 1 : i - 1;
    assign rowEn[i] = incr ? decLine[BELOW] : decLine[i];
  end

  assign strb.wrStb = wrEn;
  assign strb.rdStb = rdEn;

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rowEn) == 1);                                      // R2
  AST_PLAIN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    !incr |-> rowEn[rowAddr]);                                    // R3
  AST_NEXT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (incr && rowAddr != TOP_ROW) |-> rowEn[rowAddr + ONE_ROW]);   // R4
  AST_WRAP_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (incr && rowAddr == TOP_ROW) |-> rowEn[0]);                   // R5
endmodule

// File: rtl/rowbank_store.sv
module rowbank_store
  import rowbank_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROWS-1:0]  rowEn,
  input  bankStrobe_t      strb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] cellRow [ROWS];
  logic [WIDTH-1:0] rdMux;

  // word-line style AND-OR read path
  always_comb begin
    rdMux = '0;
    for (int i = 0; i < ROWS; i++) begin
      rdMux = rdMux | (cellRow[i] & {WIDTH{rowEn[i]}});
    end
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cellRow[i] <= '0;
      end else if (strb.wrStb && rowEn[i]) begin
        cellRow[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (strb.rdStb) begin
      rdData <= rdMux;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rdStb |=> $stable(rdData));                             // R8
  AST_RD_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> rdData == '0);                                     // R1
endmodule

// File: rtl/postinc_row_bank.sv
module postinc_row_bank
  import rowbank_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int WIDTH    = 16,
  localparam int ROWS    = 1 << ROW_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ROW_BITS-1:0] rowAddr,
  input  logic                incr,
  input  logic                wrEn,
  input  logic [WIDTH-1:0]    wrData,
  input  logic                rdEn,
  output logic [WIDTH-1:0]    rdData,
  output logic [ROWS-1:0]     rowEnable
);
  bankStrobe_t bankStrb;

  rowbank_select #(.ROW_BITS(ROW_BITS)) u_select (
    .clk     (clk),
    .rst_n   (rst_n),
    .rowAddr (rowAddr),
    .incr    (incr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .rowEn   (rowEnable),
    .strb    (bankStrb)
  );

  rowbank_store #(.ROWS(ROWS), .WIDTH(WIDTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .rowEn  (rowEnable),
    .strb   (bankStrb),
    .wrData (wrData),
    .rdData (rdData)
  );
endmodule

// File: tb/tb_postinc_row_bank.sv
module tb_postinc_row_bank;
  localparam int ROW_BITS = 4;
  localparam int ROWS = 1 << ROW_BITS;
  localparam int WIDTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ROW_BITS-1:0] rowAddr = '0;
  logic incr = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic [ROWS-1:0] rowEnable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  postinc_row_bank #(.ROW_BITS(ROW_BITS), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .rowAddr(rowAddr), .incr(incr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .rowEnable(rowEnable)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] pat(int r);
    return WIDTH'(16'h1357 ^ (r * 16'h0111));
  endfunction

  // drive at a falling edge, let one rising edge pass, return at next falling edge
  task automatic cycle(logic [ROW_BITS-1:0] a, logic inc, logic we,
                       logic [WIDTH-1:0] d, logic re);
    rowAddr = a; incr = inc; wrEn = we; wrData = d; rdEn = re;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic rd_row(int r, string req, logic [WIDTH-1:0] exp);
    cycle(ROW_BITS'(r), 1'b0, 1'b0, '0, 1'b1);
    chk(req, 32'(rdData), 32'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rdData after reset", 32'(rdData), 0);
    rd_row(7, "R1 row 7 after reset", '0);
    rd_row(ROWS - 1, "R1 top row after reset", '0);

    // exhaustive selection sweep
    for (int a = 0; a < ROWS; a++) begin
      for (int f = 0; f < 2; f++) begin
        int idx;
        rowAddr = ROW_BITS'(a); incr = f[0];
        #1;
        idx = (a + f) % ROWS;
        chk("R2 one-hot", $countones(rowEnable), 1);
        if (f == 0) chk("R3 plain row", 32'(rowEnable[idx]), 1);
        else if (a == ROWS - 1) chk("R5 wrap to row 0", 32'(rowEnable[0]), 1);
        else chk("R4 next row", 32'(rowEnable[idx]), 1);
      end
    end
    @(negedge clk);

    // write every row through the incremented path
    for (int r = 0; r < ROWS; r++) begin
      cycle(ROW_BITS'((r + ROWS - 1) % ROWS), 1'b1, 1'b1, pat(r), 1'b0);
    end
    for (int r = 0; r < ROWS; r++) begin
      rd_row(r, "R6 readback of incremented write", pat(r));
    end

    // incremented read at top address wraps to row 0
    cycle(ROW_BITS'(ROWS - 1), 1'b1, 1'b0, '0, 1'b1);
    chk("R5 wrapped read", 32'(rdData), 32'(pat(0)));

    // same-cycle write and read returns the old word
    cycle(ROW_BITS'(3), 1'b0, 1'b1, 16'hBEEF, 1'b1);
    chk("R7 read before write", 32'(rdData), 32'(pat(3)));
    rd_row(3, "R6 new word stored", 16'hBEEF);
    rd_row(4, "R6 neighbour untouched", pat(4));
    rd_row(2, "R6 lower neighbour untouched", pat(2));

    // hold while no read: write and move the address
    cycle(ROW_BITS'(5), 1'b1, 1'b1, 16'h1111, 1'b0);
    chk("R8 hold across write", 32'(rdData), 32'(pat(2)));
    cycle(ROW_BITS'(9), 1'b0, 1'b0, '0, 1'b0);
    chk("R8 hold across address change", 32'(rdData), 32'(pat(2)));
    rd_row(6, "R6 write to incremented row", 16'h1111);
    rd_row(5, "R6 base row untouched", pat(5));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule